// File: doc/BRIEF.md
# Dual-Channel Sine Test Tone Generator

This block makes two independent sine test tones, one for the left and one for the right channel of an audio DAC sample stream. Each channel owns a 16-bit phase accumulator. Its tuning word is the desired tone frequency times 65536 divided by the sample rate. The top bits of the phase address a quarter-wave sine table. The table output is then attenuated by a per-channel volume setting in half-decibel steps.

Software drives the block through a small write-only register port. Five registers are decoded: left tuning word, right tuning word, left attenuation, right attenuation and a run-control register. A write of the start code 0x4020 to the run-control register starts both tones from phase zero. Any other value written there halts them. Tuning and attenuation may be rewritten at any moment, including while tones play.

Sample pacing comes from an external strobe that pulses once per DAC sample period. Each strobe yields one signed 16-bit sample pair, qualified by a one-cycle valid pulse.

Top module: `sine_tone_gen`

## Requirements
- R1: After reset both sample outputs read 0, `out_valid` is low, both tuning words and both attenuations are 0, and the generator is halted.
- R2: A write of 0x4020 to register address 4 (run control) starts the generator and clears both phase accumulators to 0, so the first sample after the start is taken at phase 0.
- R3: While running, each `smp_tick` pulse makes `out_valid` high for exactly the following clock cycle, and in that cycle both outputs hold the new sample pair. With no tick, `out_valid` stays low.
- R4: On every tick while running, each channel's phase advances by its own tuning word modulo 65536. Between ticks the phase does not move. The sample emitted for a tick uses the phase held before that tick's advance.
- R5: At attenuation 0 the sample for phase p is round(32767·sin(2π·(k+0.5)/1024)) with k = p[15:6], to within ±1. The hardware holds only the first quarter of the wave and derives the other three quarters by mirroring the index and negating the value.
- R6: A tuning word above 0x8000 written to address 0 (left) or 1 (right) is stored and used as 0x8000.
- R7: Attenuation a is the low 8 bits written to address 2 (left) or 3 (right), split as a = 12·q + r. The gain is 10^(−r/40)·2^(−q), so 0 is full scale, and each result lies within ±3 of that ideal.
- R8: Tuning and attenuation writes made while running take effect at the next tick. They do not disturb the phase reached so far.
- R9: A write of any value other than 0x4020 to address 4 halts the generator. Both outputs read 0 from the second clock edge after the write, and later ticks raise no `out_valid`.
- R10: Writing 0x4020 again while already running restarts both channels from phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0/1 tuning L/R, 2/3 attenuation L/R, 4 run control |
| wr_data | input | 16 | Register write data |
| smp_tick | input | 1 | One-cycle pulse per DAC sample period |
| left_out | output | 16 | Signed left sample |
| right_out | output | 16 | Signed right sample |
| out_valid | output | 1 | High for one cycle after each tick while running |

## Verification
The bench aims at the quadrant seams of the quarter-wave table and at tuning words above the Nyquist limit. A mirroring slip would show up as a glitch or a sign flip at the seams. A missing clamp would let a step of 0xFFFF creep backwards instead of alternating at half the sample rate. Random attenuation values cover the boundaries between octave steps, where a divide-by-12 or mantissa error would leave the output off by a factor near 2. Live retunes, restart while running and a halt followed by idle ticks are also exercised. These expose a design that resets phase on a retune, keeps its old phase on restart, or keeps emitting valid samples after a halt.

// File: rtl/sine_tone_pkg.sv
package sine_tone_pkg;

   localparam int CH_N      = 2;
   localparam int MANT_FRAC = 15;
   localparam int MANT_W    = 16;
   localparam int OCT_STEPS = 12;

   typedef enum logic [2:0] {
      SEL_STEP_L = 3'd0,
      SEL_STEP_R = 3'd1,
      SEL_ATT_L  = 3'd2,
      SEL_ATT_R  = 3'd3,
      SEL_CTRL   = 3'd4
   } reg_sel_e;

   // Gain mantissa 10^(-r/40) in Q15 for the twelve half-dB steps of one octave
   function automatic logic [MANT_W-1:0] att_mantissa(input logic [3:0] r);
      case (r)
         4'd0:    return 16'd32768;
         4'd1:    return 16'd30935;
         4'd2:    return 16'd29205;
         4'd3:    return 16'd27571;
         4'd4:    return 16'd26029;
         4'd5:    return 16'd24573;
         4'd6:    return 16'd23198;
         4'd7:    return 16'd21900;
         4'd8:    return 16'd20675;
         4'd9:    return 16'd19519;
         4'd10:   return 16'd18427;
         default: return 16'd17396;
      endcase
   endfunction

   // amp * sin((2*idx+1)*pi / (4*2^depth_log2)), Taylor series in Q30
   function automatic int quarter_sine(input int idx, input int depth_log2, input int amp);
      longint pi_q30;
      longint x;
      longint x2;
      longint term;
      longint acc;
      pi_q30 = 64'sd3373259426;
      x      = (longint'(2 * idx + 1) * pi_q30) >>> (depth_log2 + 2);
      x2     = (x * x) >>> 30;
      term   = x;
      acc    = x;
      for (int k = 1; k <= 7; k++) begin
         term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
         acc  = acc + term;
      end
      return int'((acc * longint'(amp) + (64'sd1 <<< 29)) >>> 30);
   endfunction

endpackage

// File: rtl/sine_tone_regs.sv
module sine_tone_regs
   import sine_tone_pkg::*;
#(
   parameter int          PHASE_W    = 16,
   parameter int          ATT_W      = 8,
   parameter int          DATA_W     = 16,
   parameter logic [15:0] START_CODE = 16'h4020,
   parameter bit          CLAMP_EN   = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [2:0]                       wr_addr,
   input  logic [DATA_W-1:0]                wr_data,
   output logic [CH_N-1:0][PHASE_W-1:0]     step_o,
   output logic [CH_N-1:0][ATT_W-1:0]       att_o,
   output logic                             run_o,
   output logic                             clr_o
);

   localparam logic [PHASE_W-1:0] MAX_STEP = PHASE_W'(1) << (PHASE_W - 1);

   logic [PHASE_W-1:0] step_wr;
   logic               ctrl_wr;
   logic               start_hit;

   if (DATA_W < PHASE_W) begin : g_bad_data
      $error("sine_tone_regs: DATA_W must cover PHASE_W");
   end
   if (ATT_W > DATA_W || ATT_W < 4) begin : g_bad_att
      $error("sine_tone_regs: ATT_W out of range");
   end

   if (CLAMP_EN) begin : g_clamp
      always_comb begin
         step_wr = (wr_data[PHASE_W-1:0] > MAX_STEP) ? MAX_STEP : wr_data[PHASE_W-1:0];
      end
   end else begin : g_noclamp
      always_comb begin
         step_wr = wr_data[PHASE_W-1:0];
      end
   end

   always_comb begin
      ctrl_wr   = wr_en && (wr_addr == SEL_CTRL);
      start_hit = ctrl_wr && (wr_data == DATA_W'(START_CODE));
      clr_o     = start_hit;
   end

   for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
      localparam logic [2:0] STEP_SEL = (ch == 0) ? SEL_STEP_L : SEL_STEP_R;
      localparam logic [2:0] ATT_SEL  = (ch == 0) ? SEL_ATT_L  : SEL_ATT_R;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            step_o[ch] <= '0;
            att_o[ch]  <= '0;
         end else if (wr_en) begin
            if (wr_addr == STEP_SEL) step_o[ch] <= step_wr;
            if (wr_addr == ATT_SEL)  att_o[ch]  <= wr_data[ATT_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_o <= 1'b0;
      else if (ctrl_wr) run_o <= start_hit;
   end

   assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == SEL_CTRL && wr_data == DATA_W'(START_CODE)) |=> run_o);

   assert_other_code_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == SEL_CTRL && wr_data != DATA_W'(START_CODE)) |=> !run_o);

   if (CLAMP_EN) begin : g_clamp_chk
      assert_step_capped_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == SEL_STEP_L && wr_data[PHASE_W-1:0] > MAX_STEP)
            |=> step_o[0] == MAX_STEP);
   end

endmodule

// File: rtl/sine_tone_rom.sv
module sine_tone_rom
   import sine_tone_pkg::*;
#(
   parameter int LUT_AW = 8,
   parameter int SAMP_W = 16
) (
   input  logic [LUT_AW-1:0] addr_i,
   output logic [SAMP_W-1:0] mag_o
);

   localparam int DEPTH = 1 << LUT_AW;
   localparam int AMP   = (1 << (SAMP_W - 1)) - 1;

   if (LUT_AW < 2 || LUT_AW > 12) begin : g_bad_depth
      $error("sine_tone_rom: LUT_AW out of range");
   end

   logic [SAMP_W-1:0] rom [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      assign rom[g] = SAMP_W'(quarter_sine(g, LUT_AW, AMP));
   end

   assign mag_o = rom[addr_i];

endmodule

// File: rtl/sine_tone_chan.sv
module sine_tone_chan
   import sine_tone_pkg::*;
#(
   parameter int PHASE_W = 16,
   parameter int LUT_AW  = 8,
   parameter int SAMP_W  = 16,
   parameter int ATT_W   = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     run_i,
   input  logic                     clr_i,
   input  logic                     tick_i,
   input  logic [PHASE_W-1:0]       step_i,
   input  logic [ATT_W-1:0]         att_i,
   output logic signed [SAMP_W-1:0] sample_o,
   output logic                     valid_o
);

   localparam int IDX_W  = LUT_AW + 2;
   localparam int PROD_W = SAMP_W + 1 + MANT_W + 1;

   if (PHASE_W < IDX_W) begin : g_bad_phase
      $error("sine_tone_chan: PHASE_W too small for table index");
   end

   logic [PHASE_W-1:0]       phase_q;
   logic [IDX_W-1:0]         idx;
   logic [LUT_AW-1:0]        rom_addr;
   logic [SAMP_W-1:0]        mag;
   logic signed [SAMP_W:0]   wave;
   logic [ATT_W-1:0]         oct;
   logic [3:0]               frac;
   logic [MANT_W-1:0]        mant;
   logic signed [PROD_W-1:0] prod;
   logic signed [SAMP_W-1:0] sample_next;

   // quadrant fold: odd quadrants walk the table backwards, upper half negates
   always_comb begin
      idx      = phase_q[PHASE_W-1 -: IDX_W];
      rom_addr = idx[IDX_W-2] ? ~idx[LUT_AW-1:0] : idx[LUT_AW-1:0];
   end

   sine_tone_rom #(
      .LUT_AW (LUT_AW),
      .SAMP_W (SAMP_W)
   ) rom_i (
      .addr_i (rom_addr),
      .mag_o  (mag)
   );

   always_comb begin
      wave        = idx[IDX_W-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
      oct         = att_i / ATT_W'(OCT_STEPS);
      frac        = 4'(att_i % ATT_W'(OCT_STEPS));
      mant        = att_mantissa(frac);
      prod        = PROD_W'(wave) * $signed({1'b0, mant});
      sample_next = SAMP_W'(prod >>> (MANT_FRAC + int'(oct)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                phase_q <= '0;
      else if (clr_i)            phase_q <= '0;
      else if (run_i && tick_i)  phase_q <= phase_q + step_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_o <= '0;
         valid_o  <= 1'b0;
      end else if (!run_i) begin
         sample_o <= '0;
         valid_o  <= 1'b0;
      end else begin
         valid_o <= tick_i;
         if (tick_i) sample_o <= sample_next;
      end
   end

   assert_valid_follows_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> ($past(tick_i) && $past(run_i)));

   assert_phase_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !clr_i) |=> $stable(phase_q));

   assert_halt_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (sample_o == '0 && !valid_o));

   assert_clear_zeroes_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> phase_q == '0);

endmodule

// File: rtl/sine_tone_gen.sv
module sine_tone_gen
   import sine_tone_pkg::*;
#(
   parameter int          PHASE_W    = 16,
   parameter int          LUT_AW     = 8,
   parameter int          SAMP_W     = 16,
   parameter int          ATT_W      = 8,
   parameter int          DATA_W     = 16,
   parameter logic [15:0] START_CODE = 16'h4020,
   parameter bit          CLAMP_EN   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [2:0]               wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     smp_tick,
   output logic signed [SAMP_W-1:0] left_out,
   output logic signed [SAMP_W-1:0] right_out,
   output logic                     out_valid
);

   if (SAMP_W < 8 || SAMP_W > 24) begin : g_bad_samp
      $error("sine_tone_gen: SAMP_W out of range");
   end

   logic [CH_N-1:0][PHASE_W-1:0] step;
   logic [CH_N-1:0][ATT_W-1:0]   att;
   logic                         run;
   logic                         clr;
   logic signed [SAMP_W-1:0]     samp [CH_N];
   logic [CH_N-1:0]              vld;

   sine_tone_regs #(
      .PHASE_W    (PHASE_W),
      .ATT_W      (ATT_W),
      .DATA_W     (DATA_W),
      .START_CODE (START_CODE),
      .CLAMP_EN   (CLAMP_EN)
   ) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .step_o  (step),
      .att_o   (att),
      .run_o   (run),
      .clr_o   (clr)
   );

   for (genvar ch = 0; ch < CH_N; ch++) begin : g_chan
      sine_tone_chan #(
         .PHASE_W (PHASE_W),
         .LUT_AW  (LUT_AW),
         .SAMP_W  (SAMP_W),
         .ATT_W   (ATT_W)
      ) chan_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .run_i    (run),
         .clr_i    (clr),
         .tick_i   (smp_tick),
         .step_i   (step[ch]),
         .att_i    (att[ch]),
         .sample_o (samp[ch]),
         .valid_o  (vld[ch])
      );
   end

   assign left_out  = samp[0];
   assign right_out = samp[1];
   assign out_valid = vld[0];

   assert_channels_in_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      vld[0] == vld[1]);

endmodule

// File: tb/sine_tone_gen_tb_top.sv
module sine_tone_gen_tb_top;

   logic               clk;
   logic               rst_n;
   logic               wr_en;
   logic [2:0]         wr_addr;
   logic [15:0]        wr_data;
   logic               smp_tick;
   logic signed [15:0] left_out;
   logic signed [15:0] right_out;
   logic               out_valid;

   int total;
   int bad;
   bit done;

   logic [15:0] m_ph   [2];
   logic [15:0] m_step [2];
   logic [7:0]  m_att  [2];
   bit          m_run;

   sine_tone_gen dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .smp_tick  (smp_tick),
      .left_out  (left_out),
      .right_out (right_out),
      .out_valid (out_valid)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   function automatic real ideal(input logic [15:0] ph, input logic [7:0] a);
      real s;
      int  k;
      int  q;
      int  r;
      k = int'(ph >> 6);
      s = 32767.0 * $sin(2.0 * 3.14159265358979 * (real'(k) + 0.5) / 1024.0);
      q = int'(a) / 12;
      r = int'(a) % 12;
      return s * $pow(10.0, -real'(r) / 40.0) / $pow(2.0, real'(q));
   endfunction

   function automatic logic [15:0] capped(input logic [15:0] d);
      return (d > 16'h8000) ? 16'h8000 : d;
   endfunction

   task automatic check_eq(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_near(input string tag, input int act, input real exp, input real tol);
      real d;
      total++;
      d = real'(act) - exp;
      if (d < 0.0) d = -d;
      if (d > tol) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%f", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      case (a)
         3'd0: m_step[0] = capped(d);
         3'd1: m_step[1] = capped(d);
         3'd2: m_att[0]  = d[7:0];
         3'd3: m_att[1]  = d[7:0];
         3'd4: begin
            m_run = (d == 16'h4020);
            if (m_run) begin m_ph[0] = '0; m_ph[1] = '0; end
         end
         default: ;
      endcase
   endtask

   // one tick; output registered at the following edge, sampled at the negedge after
   task automatic tick_chk(input string tag);
      @(negedge clk);
      smp_tick = 1'b1;
      @(negedge clk);
      smp_tick = 1'b0;
      if (m_run) begin
         check_eq({tag, " valid"}, int'(out_valid), 1);
         check_near({tag, " left"}, int'(left_out), ideal(m_ph[0], m_att[0]),
                    (m_att[0] == 0) ? 1.0 : 3.0);
         check_near({tag, " right"}, int'(right_out), ideal(m_ph[1], m_att[1]),
                    (m_att[1] == 0) ? 1.0 : 3.0);
         m_ph[0] = m_ph[0] + m_step[0];
         m_ph[1] = m_ph[1] + m_step[1];
      end else begin
         check_eq({tag, " idle valid"}, int'(out_valid), 0);
         check_eq({tag, " idle left"}, int'(left_out), 0);
         check_eq({tag, " idle right"}, int'(right_out), 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      total = 0; bad = 0; done = 0;
      wr_en = 0; wr_addr = '0; wr_data = '0; smp_tick = 0;
      m_run = 0;
      for (int c = 0; c < 2; c++) begin m_ph[c] = '0; m_step[c] = '0; m_att[c] = '0; end
      void'($urandom(32'd20250611));
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;

      // R1 reset state
      check_eq("R1 left after reset", int'(left_out), 0);
      check_eq("R1 right after reset", int'(right_out), 0);
      check_eq("R1 valid after reset", int'(out_valid), 0);
      tick_chk("R1 tick while halted");

      // R2 start, R3 valid timing, R5 waveform
      wr(3'd0, 16'h0400);
      wr(3'd1, 16'h0100);
      wr(3'd4, 16'h4020);
      tick_chk("R2 first sample at phase 0");
      @(negedge clk);
      check_eq("R3 valid drops after one cycle", int'(out_valid), 0);
      for (int i = 0; i < 70; i++) tick_chk("R5 R4 full scale sweep");

      // R6 clamp of an over-Nyquist step
      wr(3'd0, 16'hFFFF);
      wr(3'd1, 16'h8001);
      for (int i = 0; i < 6; i++) tick_chk("R6 clamped step");

      // R10 restart while running
      wr(3'd0, 16'h0123);
      wr(3'd1, 16'h0777);
      for (int i = 0; i < 5; i++) tick_chk("R4 pre-restart");
      wr(3'd4, 16'h4020);
      tick_chk("R10 restart phase 0");
      tick_chk("R10 after restart");

      // R7 R8 random live retune and attenuation
      for (int i = 0; i < 300; i++) begin
         int op;
         op = int'($urandom % 7);
         case (op)
            0: wr(3'd0, 16'($urandom));
            1: wr(3'd1, 16'($urandom));
            2: wr(3'd2, 16'($urandom % 256));
            3: wr(3'd3, 16'($urandom % 256));
            4: wr(3'd0, 16'h8000 + 16'($urandom % 4));
            default: ;
         endcase
         tick_chk("R7 R8 random");
      end

      // R7 octave boundary directed
      wr(3'd0, 16'h1000);
      wr(3'd2, 16'd12);
      wr(3'd3, 16'd11);
      for (int i = 0; i < 8; i++) tick_chk("R7 octave edge");

      // R9 halt
      wr(3'd4, 16'h1234);
      @(negedge clk);
      check_eq("R9 left zero after halt", int'(left_out), 0);
      check_eq("R9 right zero after halt", int'(right_out), 0);
      tick_chk("R9 tick after halt");
      tick_chk("R9 second tick after halt");

      // R2 start after halt resumes from phase 0
      wr(3'd2, 16'd0);
      wr(3'd3, 16'd0);
      wr(3'd4, 16'h4020);
      tick_chk("R2 restart after halt");
      tick_chk("R2 second sample after restart");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule